// File: doc/BRIEF.md
# Queued serial command sequencer

This block holds the pointer logic of a queued serial peripheral. A command RAM of sixteen entries sits beside it. The sequencer walks a run of entry indices from a start pointer to an end pointer. It hands each index to a transfer engine with a one-cycle start strobe and waits for that engine's done pulse before it moves on. Software writes a 16-bit control word that holds the halt, wraparound and wrap-target controls, the chip-select idle level and the two queue pointers. The same word reads back the index of the last command that completed.

A run begins on a strobe of `start_i`. When the end entry completes, the run either stops or wraps. It wraps to entry zero or to the start pointer, as the wrap-target bit selects. Halt is graceful: the command in flight finishes and nothing further is issued. While a command is transferring, the chip-select outputs follow the select bits that the RAM entry supplies. At every other time they sit at the programmed idle level. This includes the one-cycle gap between commands.

Top module: `spi_queue_seq`

## Requirements
- R1: After reset, the control word reads 0x0000, `busy_o`, `finish_o` and `cmd_start_o` are 0, `cmd_idx_o` is 0, and `cs_o` is all zeros.
- R2: The control word layout is: bit 15 halt, bit 14 wrap enable, bit 13 wrap target (0 = entry zero, 1 = start pointer), bit 12 chip-select idle level, bits 11:8 end pointer, bits 7:4 completed pointer (read only), bits 3:0 start pointer. A write updates every field except the completed pointer, which ignores written data.
- R3: A `start_i` strobe while idle with halt = 0 causes a one-cycle `cmd_start_o` on the next cycle, with `cmd_idx_o` equal to the start pointer sampled with the strobe. A strobe while busy, or while halt = 1, is ignored.
- R4: After a command completes that is not the end entry, the next command index is the previous index plus one, modulo 16. An end pointer below the start pointer therefore runs through 15 and on to 0.
- R5: With wrap disabled, the run stops when the end-pointer entry completes. No further `cmd_start_o` is issued.
- R6: With wrap enabled, completion of the end entry is followed by a command at entry 0 if the wrap target is 0, or at the start pointer if it is 1.
- R7: With halt = 1 when a command completes, no further command is issued. Clearing halt afterwards does not resume the run; only a new start does.
- R8: In the cycle after a done pulse is accepted, the completed pointer equals the index of the command that just finished. It changes at no other time.
- R9: While a command is transferring (after its start strobe, up to and including the cycle its done is sampled), `cs_o` equals `cmd_cs_i`. At all other times every bit of `cs_o` equals the idle-level bit.
- R10: `busy_o` is high from the first `cmd_start_o` until the cycle after the final done is accepted. `finish_o` pulses for one cycle, in the first idle cycle after a run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read data, including the completed pointer |
| start_i | input | 1 | Start-queue strobe |
| cmd_start_o | output | 1 | One-cycle strobe to the transfer engine |
| cmd_idx_o | output | 4 | Command RAM index of the current command |
| cmd_done_i | input | 1 | Transfer engine done pulse |
| cmd_cs_i | input | NCS | Chip-select bits of the current RAM entry |
| cs_o | output | NCS | Chip-select outputs |
| busy_o | output | 1 | Queue running |
| finish_o | output | 1 | One-cycle pulse when a run ends |

## Verification
The assertions assume one done pulse per command, raised only while that command is transferring and never in its strobe cycle or while idle. They also assume that `start_i` and register writes are single-cycle strobes. The stimulus meets these assumptions with a bench engine that arms on each observed strobe and pulses done exactly once, after a programmable latency of one or more cycles. Register writes during a run, including setting halt mid-run, are allowed. The bench checks that such writes take effect only at the next completion.

// File: rtl/spi_queue_pkg.sv
package spi_queue_pkg;
  localparam int unsigned QDEPTH  = 16;
  localparam int unsigned PTR_W   = $clog2(QDEPTH);
  localparam int unsigned REG_W   = 16;
  localparam int unsigned HALT_B  = 15;
  localparam int unsigned WREN_B  = 14;
  localparam int unsigned WRTO_B  = 13;
  localparam int unsigned CSIV_B  = 12;
  localparam int unsigned END_LSB = 8;
  localparam int unsigned CPT_LSB = 4;
  localparam int unsigned NEW_LSB = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_XFER  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             halt;
    logic             wrap_en;
    logic             wrap_to_start;
    logic             cs_idle;
    logic [PTR_W-1:0] end_ptr;
    logic [PTR_W-1:0] start_ptr;
  } seq_cfg_t;
endpackage

// File: rtl/spi_queue_ctrl_reg.sv
module spi_queue_ctrl_reg
  import spi_queue_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [PTR_W-1:0] cpt_i,
  output seq_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  seq_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.halt          <= wdata_i[HALT_B];
      cfg_q.wrap_en       <= wdata_i[WREN_B];
      cfg_q.wrap_to_start <= wdata_i[WRTO_B];
      cfg_q.cs_idle       <= wdata_i[CSIV_B];
      cfg_q.end_ptr       <= wdata_i[END_LSB +: PTR_W];
      cfg_q.start_ptr     <= wdata_i[NEW_LSB +: PTR_W];
    end
  end

  // completed pointer comes from the sequencer; write data for it is dropped
  always_comb begin
    rdata_o                     = '0;
    rdata_o[HALT_B]             = cfg_q.halt;
    rdata_o[WREN_B]             = cfg_q.wrap_en;
    rdata_o[WRTO_B]             = cfg_q.wrap_to_start;
    rdata_o[CSIV_B]             = cfg_q.cs_idle;
    rdata_o[END_LSB +: PTR_W]   = cfg_q.end_ptr;
    rdata_o[CPT_LSB +: PTR_W]   = cpt_i;
    rdata_o[NEW_LSB +: PTR_W]   = cfg_q.start_ptr;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/spi_queue_fsm.sv
module spi_queue_fsm
  import spi_queue_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_cfg_t         cfg_i,
  input  logic             start_i,
  input  logic             done_i,
  output logic             cmd_start_o,
  output logic [PTR_W-1:0] cmd_idx_o,
  output logic             xfer_o,
  output logic             busy_o,
  output logic             finish_o,
  output logic [PTR_W-1:0] cpt_o
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(QDEPTH - 1);

  seq_state_e       state_q, state_d;
  logic [PTR_W-1:0] idx_q, idx_d;
  logic [PTR_W-1:0] cpt_q, cpt_d;
  logic             fin_q, fin_d;
  logic [PTR_W-1:0] inc_ptr;
  logic [PTR_W-1:0] wrap_ptr;
  logic             at_end;

  assign inc_ptr  = (idx_q == LAST_IDX) ? '0 : idx_q + PTR_W'(1);
  assign wrap_ptr = cfg_i.wrap_to_start ? cfg_i.start_ptr : '0;
  assign at_end   = (idx_q == cfg_i.end_ptr);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cpt_d   = cpt_q;
    fin_d   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i && !cfg_i.halt) begin
          state_d = SEQ_ISSUE;
          idx_d   = cfg_i.start_ptr;
        end
      end
      SEQ_ISSUE: state_d = SEQ_XFER;
      SEQ_XFER: begin
        if (done_i) begin
          cpt_d = idx_q;
          if (cfg_i.halt) begin
            state_d = SEQ_IDLE;
            fin_d   = 1'b1;
          end else if (at_end) begin
            if (cfg_i.wrap_en) begin
              state_d = SEQ_ISSUE;
              idx_d   = wrap_ptr;
            end else begin
              state_d = SEQ_IDLE;
              fin_d   = 1'b1;
            end
          end else begin
            state_d = SEQ_ISSUE;
            idx_d   = inc_ptr;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      cpt_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cpt_q   <= cpt_d;
      fin_q   <= fin_d;
    end
  end

  assign cmd_start_o = (state_q == SEQ_ISSUE);
  assign xfer_o      = (state_q == SEQ_XFER);
  assign busy_o      = (state_q != SEQ_IDLE);
  assign cmd_idx_o   = idx_q;
  assign cpt_o       = cpt_q;
  assign finish_o    = fin_q;
endmodule

// File: rtl/spi_queue_cs_mux.sv
module spi_queue_cs_mux #(
  parameter int unsigned NCS = 4
) (
  input  logic           xfer_i,
  input  logic           cs_idle_i,
  input  logic [NCS-1:0] cmd_cs_i,
  output logic [NCS-1:0] cs_o
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_o[g] = xfer_i ? cmd_cs_i[g] : cs_idle_i;
  end
endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
  import spi_queue_pkg::*;
#(
  parameter int unsigned NCS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             start_i,
  output logic             cmd_start_o,
  output logic [PTR_W-1:0] cmd_idx_o,
  input  logic             cmd_done_i,
  input  logic [NCS-1:0]   cmd_cs_i,
  output logic [NCS-1:0]   cs_o,
  output logic             busy_o,
  output logic             finish_o
);
  seq_cfg_t         cfg;
  logic [PTR_W-1:0] cpt;
  logic             xfer;

  spi_queue_ctrl_reg i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cpt_i   (cpt),
    .cfg_o   (cfg),
    .rdata_o (reg_rdata_o)
  );

  spi_queue_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .start_i     (start_i),
    .done_i      (cmd_done_i),
    .cmd_start_o (cmd_start_o),
    .cmd_idx_o   (cmd_idx_o),
    .xfer_o      (xfer),
    .busy_o      (busy_o),
    .finish_o    (finish_o),
    .cpt_o       (cpt)
  );

  spi_queue_cs_mux #(.NCS(NCS)) i_cs (
    .xfer_i    (xfer),
    .cs_idle_i (cfg.cs_idle),
    .cmd_cs_i  (cmd_cs_i),
    .cs_o      (cs_o)
  );
endmodule

// File: rtl/spi_queue_seq_chk.sv
module spi_queue_seq_chk #(
  parameter int unsigned NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [15:0]    reg_rdata_o,
  input logic           start_i,
  input logic           cmd_start_o,
  input logic [3:0]     cmd_idx_o,
  input logic           cmd_done_i,
  input logic [NCS-1:0] cs_o,
  input logic           busy_o,
  input logic           finish_o
);
  logic accept;
  assign accept = busy_o && cmd_done_i && !cmd_start_o;

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |=> !cmd_start_o); // R3
  AST_FIRST_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !reg_rdata_o[15]) |=> (cmd_start_o && cmd_idx_o == $past(reg_rdata_o[3:0]))); // R3
  AST_CS_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_o == {NCS{reg_rdata_o[12]}})); // R9
  AST_CPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(reg_rdata_o[7:4])); // R8
  AST_CPT_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (reg_rdata_o[7:4] == $past(cmd_idx_o))); // R8
  AST_NO_WRAP_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_idx_o == reg_rdata_o[11:8] && !reg_rdata_o[14]) |=> (!busy_o && finish_o)); // R5
  AST_HALT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && reg_rdata_o[15]) |=> (!busy_o && finish_o)); // R7
  AST_FINISH_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |-> (!busy_o && $past(busy_o))); // R10
endmodule

bind spi_queue_seq spi_queue_seq_chk #(.NCS(NCS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rdata_o (reg_rdata_o),
  .start_i     (start_i),
  .cmd_start_o (cmd_start_o),
  .cmd_idx_o   (cmd_idx_o),
  .cmd_done_i  (cmd_done_i),
  .cs_o        (cs_o),
  .busy_o      (busy_o),
  .finish_o    (finish_o)
);

// File: tb/test_spi_queue_seq.sv
module test_spi_queue_seq;
  localparam int NCS = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           we = 1'b0;
  logic [15:0]    wd = '0;
  logic [15:0]    rdata;
  logic           start = 1'b0;
  logic           cmd_start;
  logic [3:0]     cmd_idx;
  logic           done = 1'b0;
  logic [NCS-1:0] cs_in = '0;
  logic [NCS-1:0] cs;
  logic           busy;
  logic           fin;

  always #4 clk = ~clk;

  spi_queue_seq #(.NCS(NCS)) i_spi_queue_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_wdata_i (wd),
    .reg_rdata_o (rdata),
    .start_i     (start),
    .cmd_start_o (cmd_start),
    .cmd_idx_o   (cmd_idx),
    .cmd_done_i  (done),
    .cmd_cs_i    (cs_in),
    .cs_o        (cs),
    .busy_o      (busy),
    .finish_o    (fin)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int       m_state = 0;  // 0 idle, 1 strobe, 2 transfer
  logic [3:0] m_idx = '0, m_cpt = '0, m_end = '0, m_new = '0;
  bit       m_halt = 0, m_wren = 0, m_wrto = 0, m_csiv = 0, m_fin = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_idx = '0; m_cpt = '0; m_end = '0; m_new = '0;
      m_halt = 0; m_wren = 0; m_wrto = 0; m_csiv = 0; m_fin = 0;
    end else begin
      bit f;
      f = 0;
      case (m_state)
        0: if (start && !m_halt) begin m_state = 1; m_idx = m_new; end
        1: m_state = 2;
        default: if (done) begin
          m_cpt = m_idx;
          if (m_halt) begin m_state = 0; f = 1; end
          else if (m_idx == m_end) begin
            if (m_wren) begin m_idx = m_wrto ? m_new : 4'd0; m_state = 1; end
            else begin m_state = 0; f = 1; end
          end else begin
            m_idx = m_idx + 4'd1; m_state = 1;
          end
        end
      endcase
      m_fin = f;
      if (we) begin
        m_halt = wd[15]; m_wren = wd[14]; m_wrto = wd[13]; m_csiv = wd[12];
        m_end = wd[11:8]; m_new = wd[3:0];
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R10 busy", 32'(busy), 32'(m_state != 0));
      chk("R10 finish", 32'(fin), 32'(m_fin));
      chk("R3 cmd_start", 32'(cmd_start), 32'(m_state == 1));
      chk("R4 cmd_idx", 32'(cmd_idx), 32'(m_idx));
      chk("R2 rdata", 32'(rdata), 32'({m_halt, m_wren, m_wrto, m_csiv, m_end, m_cpt, m_new}));
      chk("R9 cs", 32'(cs), 32'((m_state == 2) ? cs_in : {NCS{m_csiv}}));
    end
  end

  // transfer engine: one done per strobe after lat cycles
  int lat = 2;
  int cnt = 0;
  always @(negedge clk) begin
    cs_in = cs_in + 1'b1;
    done = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) done = 1'b1;
    end
    if (rst_n && cmd_start) cnt = lat;
  end

  logic [3:0] q_idx[$];
  always @(negedge clk) if (rst_n && cmd_start) q_idx.push_back(cmd_idx);

  task automatic chk_q(string tag, int pos, int exp);
    if (pos < q_idx.size()) chk(tag, 32'(q_idx[pos]), 32'(exp));
    else chk(tag, 32'hFFFF_FFFF, 32'(exp));
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_fin();
    int n = 0;
    do begin @(negedge clk); n++; end while (fin !== 1'b1 && n < 5000);
  endtask

  task automatic wait_q(int sz);
    int n = 0;
    while (q_idx.size() < sz && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired act=1 exp=0");
    summary();
    $finish;
  end

  initial begin
    int sz;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk("R1 rdata", 32'(rdata), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 cs", 32'(cs), 32'h0);
    chk("R1 cmd_start", 32'(cmd_start), 32'h0);
    chk("R1 finish", 32'(fin), 32'h0);
    chk("R1 cmd_idx", 32'(cmd_idx), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: completed-pointer write bits dropped, idle level 1
    wr(16'h15F2);
    #2;
    chk("R2 rdata after write", 32'(rdata), 32'h1502);
    chk("R9 idle cs high", 32'(cs), 32'hF);

    // R5 R3: 2..5 without wrap, second start while busy ignored
    lat = 3; q_idx.delete();
    go();
    repeat (4) @(negedge clk);
    go();
    wait_fin();
    @(negedge clk); #2;
    chk("R5 count", 32'(q_idx.size()), 32'd4);
    chk_q("R3 first", 0, 2);
    chk_q("R4 second", 1, 3);
    chk_q("R5 last", 3, 5);
    chk("R8 cpt", 32'(rdata[7:4]), 32'd5);
    chk("R5 busy low", 32'(busy), 32'h0);

    // R4: end below start runs through 15
    wr(16'h010E);
    lat = 1; q_idx.delete();
    go();
    wait_fin();
    @(negedge clk); #2;
    chk("R4 count", 32'(q_idx.size()), 32'd4);
    chk_q("R4 e0", 0, 14);
    chk_q("R4 e1", 1, 15);
    chk_q("R4 e2", 2, 0);
    chk_q("R4 e3", 3, 1);
    chk("R8 cpt wrap", 32'(rdata[7:4]), 32'd1);

    // R6: wrap to entry zero, then R7 halt
    wr(16'h4403);
    lat = 2; q_idx.delete();
    go();
    wait_q(7);
    chk_q("R6 z0", 0, 3);
    chk_q("R6 z1", 1, 4);
    chk_q("R6 z2", 2, 0);
    chk_q("R6 z3", 3, 1);
    chk_q("R6 z6", 6, 4);
    wr(16'hC403);
    wait_fin();
    sz = q_idx.size();
    repeat (30) @(negedge clk);
    #2;
    chk("R7 halted busy", 32'(busy), 32'h0);
    chk("R7 no more cmds", 32'(q_idx.size()), 32'(sz));

    // R6: wrap to start pointer
    wr(16'h6403);
    lat = 4; q_idx.delete();
    go();
    wait_q(6);
    chk_q("R6 s0", 0, 3);
    chk_q("R6 s1", 1, 4);
    chk_q("R6 s2", 2, 3);
    chk_q("R6 s3", 3, 4);
    chk_q("R6 s5", 5, 4);
    wr(16'hE403);
    wait_fin();
    sz = q_idx.size();
    // R7: clearing halt does not resume
    wr(16'h6403);
    repeat (20) @(negedge clk);
    #2;
    chk("R7 no resume busy", 32'(busy), 32'h0);
    chk("R7 no resume cmds", 32'(q_idx.size()), 32'(sz));

    // R3: start ignored while halt set
    wr(16'hE403);
    go();
    repeat (5) @(negedge clk);
    #2;
    chk("R3 halt blocks start", 32'(busy), 32'h0);
    chk("R3 halt no cmd", 32'(q_idx.size()), 32'(sz));

    // R5 R10: short run restart
    wr(16'h0403);
    lat = 1; q_idx.delete();
    go();
    wait_fin();
    #2;
    chk("R10 finish pulse", 32'(fin), 32'h1);
    @(negedge clk); #2;
    chk("R10 finish one cycle", 32'(fin), 32'h0);
    chk("R5 short count", 32'(q_idx.size()), 32'd2);
    chk_q("R5 short last", 1, 4);
    chk("R9 idle cs low", 32'(cs), 32'h0);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule